// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This unit decides whether a conditional branch or a conditional move takes effect. It is purely combinational. It takes the condition field of the instruction and, depending on the mode, either a source register value or the arithmetic flags. It returns one bit that says whether the condition holds.

In register mode, the unit compares a signed register value with zero, using a 3-bit test code. In flag mode, it applies one of sixteen 4-bit conditions to a flag nibble. A select input chooses that nibble from one of two sets: the flags produced by 32-bit operations or the flags produced by 64-bit operations. Both decoders share the same shape. The low bits pick a base test and the top bit of the code inverts it. A register code that names no test gives a false result and raises a separate illegal indication.

Top module: `cond_eval_unit`

## Requirements
- R1: In register mode (`flag_mode`=0), code 1 is true exactly when `src_val` is zero, and code 5 is true exactly when it is nonzero. The code is `cond_code[2:0]`.
- R2: In register mode, `src_val` is a signed two's-complement number whose sign is bit W-1. Code 3 is true when it is below zero, code 2 when at or below zero, code 6 when above zero, and code 7 when at or above zero.
- R3: In register mode, codes 0 and 4 give `cond_true`=0 and `cond_bad`=1. Every other register code gives `cond_bad`=0.
- R4: In register mode, `cond_code[3]`, both flag nibbles and `wide_sel` have no effect on either output.
- R5: In flag mode (`flag_mode`=1), each nibble is laid out as {N,Z,V,C} on bits 3..0. Code 8 is always true and code 0 is never true. Code 1 yields Z and code 9 yields NOT Z.
- R6: In flag mode, the signed comparisons are as follows. Code 10 is NOT(Z OR (N XOR V)). Code 2 is Z OR (N XOR V). Code 11 is NOT(N XOR V). Code 3 is N XOR V.
- R7: In flag mode, the unsigned comparisons are as follows. Code 12 is NOT(C OR Z). Code 4 is C OR Z. Code 13 is NOT C. Code 5 is C.
- R8: In flag mode, the single-flag tests are as follows. Code 14 is NOT N, code 6 is N, code 15 is NOT V and code 7 is V.
- R9: In flag mode, `wide_sel`=0 evaluates `flags_w32` and `wide_sel`=1 evaluates `flags_w64`. The nibble that is not selected has no effect.
- R10: In flag mode, `src_val` has no effect and `cond_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| flag_mode | input | 1 | 0 selects a register-versus-zero test, 1 selects a flag test |
| cond_code | input | 4 | Condition field; register mode uses bits 2..0 only |
| src_val | input | W (64) | Source register value, signed |
| flags_w32 | input | 4 | Flags {N,Z,V,C} from 32-bit operations |
| flags_w64 | input | 4 | Flags {N,Z,V,C} from 64-bit operations |
| wide_sel | input | 1 | 0 selects flags_w32, 1 selects flags_w64 |
| cond_true | output | 1 | The condition holds |
| cond_bad | output | 1 | The register-mode code names no test |

## Verification
Both outputs are combinational, so each result is due in the same cycle as its stimulus and passes through no register. The bench changes the inputs on the falling clock edge. It samples two nanoseconds later, well inside the low phase and away from any rising edge. The flag sweep covers all sixteen codes against all sixteen nibbles in both sets. During that sweep the unselected set is held at the complement of the selected one and `src_val` is varied. The register sweep runs all eight codes over signed boundary values while the ignored inputs are toggled.

// File: rtl/cond_eval_pkg.sv
// Shared definitions for the condition evaluator.
// Assumes flag nibbles are packed {N,Z,V,C} from bit 3 down to bit 0.
package cond_eval_pkg;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // base tests; the top code bit inverts each one
    typedef enum logic [2:0] {
        CC_NEVER = 3'd0,
        CC_EQ    = 3'd1,
        CC_LE    = 3'd2,
        CC_LT    = 3'd3,
        CC_LEU   = 3'd4,
        CC_CS    = 3'd5,
        CC_NEG   = 3'd6,
        CC_VS    = 3'd7
    } cc_base_e;

    // register-test bases; code bit 2 inverts; bases 0 has no test
    typedef enum logic [1:0] {
        RZ_NONE = 2'd0,
        RZ_Z    = 2'd1,
        RZ_LEZ  = 2'd2,
        RZ_LZ   = 2'd3
    } rz_base_e;
endpackage

// File: rtl/reg_zero_test.sv
// Compares a signed register value with zero.
// Code bits [1:0] pick the base test, bit [2] inverts it.
// Base 0 names no test: result is 0 and bad is raised.
module reg_zero_test
    import cond_eval_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] val,
    input  logic [2:0]   code,
    output logic         hit,
    output logic         bad
);
    localparam int SIGN_BIT = W - 1;

    logic is_zero;
    logic is_neg;
    logic base_hit;
    rz_base_e base;

    // derive sign and zero properties of the operand
    always_comb begin
        is_zero = (val == '0);
        is_neg  = val[SIGN_BIT];
    end

    // evaluate the base test and apply inversion
    always_comb begin
        base = rz_base_e'(code[1:0]);
        unique case (base)
            RZ_Z:    base_hit = is_zero;
            RZ_LEZ:  base_hit = is_zero | is_neg;
            RZ_LZ:   base_hit = is_neg;
            default: base_hit = 1'b0;
        endcase
        bad = (base == RZ_NONE);
        hit = bad ? 1'b0 : (base_hit ^ code[2]);
    end
endmodule

// File: rtl/flag_cond_test.sv
// Applies a 4-bit condition to one {N,Z,V,C} flag nibble.
// Code bits [2:0] pick the base test, bit [3] inverts it.
module flag_cond_test
    import cond_eval_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] code,
    output logic       hit
);
    logic     base_hit;
    logic     sgn_lt;
    cc_base_e base;

    // signed-less-than term shared by several tests
    always_comb sgn_lt = flags.n ^ flags.v;

    // evaluate the base test and apply inversion
    always_comb begin
        base = cc_base_e'(code[2:0]);
        unique case (base)
            CC_NEVER: base_hit = 1'b0;
            CC_EQ:    base_hit = flags.z;
            CC_LE:    base_hit = flags.z | sgn_lt;
            CC_LT:    base_hit = sgn_lt;
            CC_LEU:   base_hit = flags.c | flags.z;
            CC_CS:    base_hit = flags.c;
            CC_NEG:   base_hit = flags.n;
            CC_VS:    base_hit = flags.v;
            default:  base_hit = 1'b0;
        endcase
        hit = base_hit ^ code[3];
    end
endmodule

// File: rtl/cond_eval_unit.sv
// Top of the condition evaluator: picks a register-versus-zero test or a
// flag test on the 32-bit or 64-bit flag set. Purely combinational.
// Assumes the caller holds inputs stable while it uses cond_true.
module cond_eval_unit
    import cond_eval_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         flag_mode,
    input  logic [3:0]   cond_code,
    input  logic [W-1:0] src_val,
    input  logic [3:0]   flags_w32,
    input  logic [3:0]   flags_w64,
    input  logic         wide_sel,
    output logic         cond_true,
    output logic         cond_bad
);
    localparam int NSETS = 2;

    flags_t sets [NSETS];
    flags_t sel_flags;
    logic   rz_hit;
    logic   rz_bad;
    logic   fc_hit;

    // gather the flag sets so the select indexes them
    always_comb begin
        sets[0] = flags_t'(flags_w32);
        sets[1] = flags_t'(flags_w64);
    end

    // choose the flag set named by wide_sel
    always_comb sel_flags = sets[wide_sel];

    reg_zero_test #(.W(W)) rz_i (
        .val  (src_val),
        .code (cond_code[2:0]),
        .hit  (rz_hit),
        .bad  (rz_bad)
    );

    flag_cond_test fc_i (
        .flags (sel_flags),
        .code  (cond_code),
        .hit   (fc_hit)
    );

    // route the active evaluator to the outputs
    always_comb begin
        cond_true = flag_mode ? fc_hit : rz_hit;
        cond_bad  = flag_mode ? 1'b0   : rz_bad;
    end
endmodule

// File: rtl/cond_eval_chk.sv
// Checker for cond_eval_unit; combinational, so uses immediate assertions.
module cond_eval_chk #(
    parameter int W = 64
) (
    input logic         flag_mode,
    input logic [3:0]   cond_code,
    input logic [W-1:0] src_val,
    input logic [3:0]   flags_w32,
    input logic [3:0]   flags_w64,
    input logic         wide_sel,
    input logic         cond_true,
    input logic         cond_bad
);
    logic [3:0] f;
    // the flag nibble the block should be reading
    always_comb f = wide_sel ? flags_w64 : flags_w32;

    // each check in its own process keeps failures separate
    always_comb if (!flag_mode && cond_code[2:0] == 3'd1)
        a_r1_zero_test: assert (cond_true == (src_val == '0));
    always_comb if (!flag_mode && cond_code[2:0] == 3'd3)
        a_r2_neg_test: assert (cond_true == src_val[W-1]);
    always_comb if (cond_bad)
        a_r3_bad_is_false: assert (!cond_true && !flag_mode);
    always_comb if (flag_mode && cond_code == 4'd8)
        a_r5_always: assert (cond_true);
    always_comb if (flag_mode && cond_code == 4'd0)
        a_r5_never: assert (!cond_true);
    always_comb if (flag_mode && cond_code == 4'd5)
        a_r7_carry_set: assert (cond_true == f[0]);
    always_comb if (flag_mode && cond_code == 4'd15)
        a_r8_overflow_clear: assert (cond_true == !f[1]);
    always_comb if (flag_mode)
        a_r10_no_bad_in_flag_mode: assert (!cond_bad);
endmodule

bind cond_eval_unit cond_eval_chk #(.W(W)) chk_i (
    .flag_mode (flag_mode),
    .cond_code (cond_code),
    .src_val   (src_val),
    .flags_w32 (flags_w32),
    .flags_w64 (flags_w64),
    .wide_sel  (wide_sel),
    .cond_true (cond_true),
    .cond_bad  (cond_bad)
);

// File: tb/cond_eval_unit_tb_top.sv
module cond_eval_unit_tb_top;
    localparam int W = 64;

    logic         clk;
    logic         rst_n;
    logic         flag_mode;
    logic [3:0]   cond_code;
    logic [W-1:0] src_val;
    logic [3:0]   flags_w32;
    logic [3:0]   flags_w64;
    logic         wide_sel;
    logic         cond_true;
    logic         cond_bad;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    cond_eval_unit #(.W(W)) dut_i (
        .flag_mode (flag_mode),
        .cond_code (cond_code),
        .src_val   (src_val),
        .flags_w32 (flags_w32),
        .flags_w64 (flags_w64),
        .wide_sel  (wide_sel),
        .cond_true (cond_true),
        .cond_bad  (cond_bad)
    );

    // 125 MHz
    initial clk = 1'b0;
    always #4 clk = ~clk;

    // reference for flag mode, written per named condition
    function automatic logic ref_flag(input logic [3:0] c, input logic [3:0] fl);
        logic n, z, v, cy;
        n = fl[3]; z = fl[2]; v = fl[1]; cy = fl[0];
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return z;
            4'd2:  return z | (n ^ v);
            4'd3:  return n ^ v;
            4'd4:  return cy | z;
            4'd5:  return cy;
            4'd6:  return n;
            4'd7:  return v;
            4'd8:  return 1'b1;
            4'd9:  return !z;
            4'd10: return !(z | (n ^ v));
            4'd11: return !(n ^ v);
            4'd12: return !(cy | z);
            4'd13: return !cy;
            4'd14: return !n;
            default: return !v;
        endcase
    endfunction

    // reference for register mode, using signed arithmetic comparison
    function automatic logic ref_reg(input logic [2:0] c, input logic signed [W-1:0] x);
        case (c)
            3'd1: return x == 0;
            3'd2: return x <= 0;
            3'd3: return x < 0;
            3'd5: return x != 0;
            3'd6: return x > 0;
            3'd7: return x >= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string flag_tag(input logic [3:0] c);
        case (c)
            4'd0, 4'd8, 4'd1, 4'd9: return "R5";
            4'd2, 4'd3, 4'd10, 4'd11: return "R6";
            4'd4, 4'd5, 4'd12, 4'd13: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [3:0] c, input logic [W-1:0] x,
                         input logic [3:0] f32, input logic [3:0] f64, input logic ws);
        @(negedge clk);
        flag_mode = m; cond_code = c; src_val = x;
        flags_w32 = f32; flags_w64 = f64; wide_sel = ws;
        #2;
    endtask

    logic [W-1:0] vals [8];

    initial begin
        vals[0] = '0;
        vals[1] = 64'd1;
        vals[2] = '1;
        vals[3] = {1'b0, {(W-1){1'b1}}};
        vals[4] = {1'b1, {(W-1){1'b0}}};
        vals[5] = 64'h0000_0001_0000_0000;
        vals[6] = 64'h8000_0000_0000_0001;
        vals[7] = 64'h0000_0000_8000_0000;

        rst_n = 1'b0;
        flag_mode = 1'b0; cond_code = 4'd0; src_val = '0;
        flags_w32 = 4'd0; flags_w64 = 4'd0; wide_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // idle inputs: register code 0 is illegal and false (R3)
        check("R3", cond_true, 1'b0, "reset-state true");
        check("R3", cond_bad, 1'b1, "reset-state bad");

        // register sweep: all codes, boundary values, disturbing ignored inputs (R1 R2 R3 R4)
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 16; c++) begin
                for (int fv = 0; fv < 4; fv++) begin
                    logic [2:0] rc;
                    string tg;
                    rc = c[2:0];
                    apply(1'b0, c[3:0], vals[k], 4'(fv * 5), 4'(~(fv * 5)), fv[0]);
                    tg = (rc == 3'd1 || rc == 3'd5) ? "R1" :
                         (rc == 3'd0 || rc == 3'd4) ? "R3" : "R2";
                    if (c >= 8 || fv != 0) tg = "R4";
                    check(tg, cond_true, ref_reg(rc, vals[k]), $sformatf("reg code=%0d val=%h", c, vals[k]));
                    check(tg == "R4" ? "R4" : "R3", cond_bad, (rc == 3'd0 || rc == 3'd4),
                          $sformatf("reg bad code=%0d", c));
                end
            end
        end

        // flag sweep: every code, every nibble, both sets (R5 R6 R7 R8 R9 R10)
        for (int ws = 0; ws < 2; ws++) begin
            for (int c = 0; c < 16; c++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [3:0] sel, oth;
                    sel = f[3:0];
                    oth = ~sel;
                    if (ws == 0) apply(1'b1, c[3:0], vals[f % 8], sel, oth, 1'b0);
                    else         apply(1'b1, c[3:0], vals[f % 8], oth, sel, 1'b1);
                    check(flag_tag(c[3:0]), cond_true, ref_flag(c[3:0], sel),
                          $sformatf("flag code=%0d nzvc=%b wide=%0d", c, sel, ws));
                    check("R10", cond_bad, 1'b0, $sformatf("flag bad code=%0d", c));
                end
            end
        end

        // R9: same code, differing sets, select flips the answer
        apply(1'b1, 4'd1, '0, 4'b0100, 4'b0000, 1'b0);
        check("R9", cond_true, 1'b1, "eq on 32-bit set Z=1");
        apply(1'b1, 4'd1, '0, 4'b0100, 4'b0000, 1'b1);
        check("R9", cond_true, 1'b0, "eq on 64-bit set Z=0");
        // R10: register value irrelevant in flag mode
        apply(1'b1, 4'd9, '1, 4'b0000, 4'b0000, 1'b0);
        check("R10", cond_true, 1'b1, "ne with nonzero reg, Z=0");
        apply(1'b1, 4'd9, '0, 4'b0100, 4'b0100, 1'b0);
        check("R10", cond_true, 1'b0, "ne with zero reg, Z=1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule